// File: doc/BRIEF.md
# HDLC Frame Serialiser with Tagged Byte Queue

This block turns a queue of bytes into an HDLC bit stream, one bit per pulse of a bit-rate strobe. Each byte comes with two tags. One marks the last byte of a packet. The other marks a byte that must be replaced by an abort. Because packet ends travel in-band with the data, several packets can sit in the queue at once, and they go out separated by a single flag.

The serialiser adds the opening and closing flags itself. It inserts a zero after five ones in the data and checksum, and it appends a 16-bit frame check sequence. Between frames the line carries one of two idle patterns: all ones, or repeated flags. A mode input chooses between them. If the queue runs dry inside a packet, the block sends an abort on its own and reports an underrun.

Bytes enter through a valid/ready stream. `in_valid` low means the queue is empty. `in_ready` pulses for one clock, in a strobe cycle, when the byte and its tags are taken. The source keeps the byte stable while `in_valid` is high and advances only when it sees the handshake. Back-pressure is therefore set entirely by the bit rate: at most one byte is taken per eight or more strobes.

Top module: `hdlc_tagged_tx`

## Requirements
- R1: During and right after reset, `tx_bit` is 1, `in_ready` is 0, and `frame_done`, `abort_done` and `underrun` are all 0.
- R2: When the queue is empty and `fill_flags` is 0 (or `tx_en` is 0), the line carries continuous ones.
- R3: When the queue is empty, `tx_en` is 1 and `fill_flags` is 1, the line carries back-to-back flags. In time order a flag is 0,1,1,1,1,1,1,0.
- R4: In ones-idle, a newly arrived byte waits until the current group of eight ones is complete. An opening flag follows, and then the packet data.
- R5: In flag-idle, the flag already being sent serves as the opening flag. The first byte is taken at the end of that flag, no more than 8 strobes after it arrives.
- R6: Data bytes are sent least significant bit first. After any five consecutive ones in data or checksum, a 0 is inserted. Flags and aborts are never stuffed.
- R7: After the last bit of a byte tagged `in_eop`, the block sends the 16-bit checksum and then a closing flag. The checksum is CRC-16 with polynomial x^16+x^12+x^5+1, computed LSB first (reflected constant 0x8408), preset to 0xFFFF and sent complemented, low bit first. A correct frame gives a residue of 0xF0B8 at the receiver. `frame_done` pulses in the cycle in which the first closing-flag bit appears.
- R8: When the next packet is already queued, exactly one flag separates the two packets.
- R9: A byte tagged `in_abort` is consumed but not sent. Eight unstuffed ones are sent in its place, and all earlier bytes of the packet are sent in full. `abort_done` pulses in the cycle in which the first abort bit appears. `in_abort` takes priority over `in_eop`.
- R10: If the queue is empty when a packet needs its next byte and no end or abort tag has been seen, an abort is sent. `underrun` pulses together with `abort_done`.
- R11: After a closing flag or an abort, with the queue empty, the line returns to the selected idle pattern.
- R12: `tx_bit` changes only at clock edges where `bit_stb` is 1. `in_ready` is 1 only in `bit_stb` cycles, and each such cycle takes one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Allows new packets to start; 0 forces ones-idle between frames |
| fill_flags | input | 1 | Idle pattern select: 1 = flags, 0 = ones |
| bit_stb | input | 1 | Bit-rate strobe, one line bit per high cycle |
| in_valid | input | 1 | Queue holds a byte (0 = empty) |
| in_ready | output | 1 | Byte and tags are taken this cycle |
| in_data | input | 8 | Queued byte |
| in_eop | input | 1 | Byte is the last of its packet |
| in_abort | input | 1 | Byte is to be replaced by an abort |
| tx_bit | output | 1 | Serial line bit |
| frame_done | output | 1 | Pulse: closing flag has started |
| abort_done | output | 1 | Pulse: abort has started |
| underrun | output | 1 | Pulse: abort was caused by an empty queue |

## Verification
A wrong stuffing count or a checksum register that drifts out of step shows up within one frame: the receiver model in the bench fails on destuffing or on the checksum residue of the next closing flag. A wrong sequencer state shows up within eight strobes. It appears either as a broken idle pattern, as an extra or missing flag between packets, or as an abort that starts at the wrong bit position. The bench measures these against the strobe count.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [2:0] {
    U_MARK  = 3'd0,
    U_FLAG  = 3'd1,
    U_DATA  = 3'd2,
    U_FCS   = 3'd3,
    U_ABORT = 3'd4
  } unit_e;

  localparam logic [7:0]  FLAG_OCTET  = 8'h7E;
  localparam logic [7:0]  ONES_OCTET  = 8'hFF;
  localparam logic [15:0] CRC_POLY_LSB = 16'h8408;
  localparam logic [15:0] CRC_PRESET   = 16'hFFFF;
endpackage

// File: rtl/hdlc_crc16.sv
module hdlc_crc16 #(
  parameter int          CRC_W  = 16,
  parameter logic [15:0] POLY   = 16'h8408,
  parameter logic [15:0] PRESET = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             upd,
  input  logic             din,
  output logic [CRC_W-1:0] crc_q
);
  logic fb;
  assign fb = crc_q[0] ^ din;

  always_ff @(posedge clk) begin
    if (!rst_n || init) crc_q <= PRESET[CRC_W-1:0];
    else if (upd)       crc_q <= (crc_q >> 1) ^ (fb ? POLY[CRC_W-1:0] : '0);
  end
endmodule

// File: rtl/hdlc_bit_serializer.sv
module hdlc_bit_serializer #(
  parameter int WORD_W = 16,
  parameter int RUN    = 5,
  localparam int CNT_W = $clog2(WORD_W + 1),
  localparam int RUN_W = $clog2(RUN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [WORD_W-1:0] load_word,
  input  logic [CNT_W-1:0]  load_len,
  input  logic              load_stuff,
  output logic              need_load,
  output logic              stuff_now,
  output logic              emit_bit,
  output logic              bit_q
);
  logic [WORD_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic [RUN_W-1:0]  run, run_base;
  logic              stuff_on;

  assign stuff_now = stuff_on && (run == RUN_W'(RUN));
  assign need_load = (cnt == '0) && !stuff_now;
  assign emit_bit  = stuff_now ? 1'b0 : ((cnt == '0) ? load_word[0] : sh[0]);
  assign run_base  = stuff_on ? run : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh       <= '0;
      cnt      <= '0;
      run      <= '0;
      stuff_on <= 1'b0;
      bit_q    <= 1'b1;
    end else if (stb) begin
      bit_q <= emit_bit;
      if (stuff_now) begin
        run <= '0;
      end else if (cnt == '0) begin
        sh       <= load_word >> 1;
        cnt      <= load_len - CNT_W'(1);
        stuff_on <= load_stuff;
        run      <= (load_stuff && load_word[0]) ? run_base + RUN_W'(1) : '0;
      end else begin
        sh  <= sh >> 1;
        cnt <= cnt - CNT_W'(1);
        run <= (stuff_on && sh[0]) ? run + RUN_W'(1) : '0;
      end
    end
  end

  AST_STUFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && stuff_now) |=> !bit_q) else $error("stuffed bit not zero"); // R6
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(bit_q)) else $error("line bit moved without strobe"); // R12
endmodule

// File: rtl/hdlc_tagged_tx.sv
module hdlc_tagged_tx
  import hdlc_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FCS_W  = 16,
  localparam int CNT_W = $clog2(FCS_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              fill_flags,
  input  logic              bit_stb,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_eop,
  input  logic              in_abort,
  output logic              tx_bit,
  output logic              frame_done,
  output logic              abort_done,
  output logic              underrun
);
  unit_e             unit_q, nxt, idle_u;
  logic              eop_q;
  logic              pop, fin, abt, und, start, take;
  logic              need_load, stuff_now, emit_bit;
  logic [FCS_W-1:0]  load_word, crc_q;
  logic [CNT_W-1:0]  load_len;
  logic              load_stuff, crc_init, crc_upd;

  assign start  = tx_en && in_valid;
  assign idle_u = (tx_en && fill_flags) ? U_FLAG : U_MARK;

  always_comb begin
    nxt = unit_q;
    pop = 1'b0;
    fin = 1'b0;
    abt = 1'b0;
    und = 1'b0;
    case (unit_q)
      U_DATA: begin
        if (eop_q) nxt = U_FCS;
        else if (in_valid) begin
          pop = 1'b1;
          if (in_abort) begin nxt = U_ABORT; abt = 1'b1; end
          else nxt = U_DATA;
        end else begin
          nxt = U_ABORT; abt = 1'b1; und = 1'b1;
        end
      end
      U_FCS: begin nxt = U_FLAG; fin = 1'b1; end
      U_FLAG: begin
        if (start) begin
          pop = 1'b1;
          if (in_abort) begin nxt = U_ABORT; abt = 1'b1; end
          else nxt = U_DATA;
        end else nxt = idle_u;
      end
      default: nxt = start ? U_FLAG : idle_u;
    endcase
  end

  always_comb begin
    load_stuff = 1'b0;
    load_len   = CNT_W'(8);
    case (nxt)
      U_DATA: begin
        load_word  = {{(FCS_W-DATA_W){1'b0}}, in_data};
        load_len   = CNT_W'(DATA_W);
        load_stuff = 1'b1;
      end
      U_FCS: begin
        load_word  = ~crc_q;
        load_len   = CNT_W'(FCS_W);
        load_stuff = 1'b1;
      end
      U_FLAG:  load_word = FCS_W'(FLAG_OCTET);
      default: load_word = FCS_W'(ONES_OCTET);
    endcase
  end

  assign take     = bit_stb && need_load;
  assign in_ready = take && pop;
  assign crc_init = take && (nxt != U_DATA) && (nxt != U_FCS);
  assign crc_upd  = bit_stb && !stuff_now && (take ? (nxt == U_DATA) : (unit_q == U_DATA));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unit_q     <= U_MARK;
      eop_q      <= 1'b0;
      frame_done <= 1'b0;
      abort_done <= 1'b0;
      underrun   <= 1'b0;
    end else begin
      frame_done <= take && fin;
      abort_done <= take && abt;
      underrun   <= take && und;
      if (take) unit_q <= nxt;
      if (in_ready) eop_q <= in_eop && !in_abort;
    end
  end

  hdlc_crc16 #(.CRC_W(FCS_W), .POLY(CRC_POLY_LSB), .PRESET(CRC_PRESET)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .upd(crc_upd), .din(emit_bit), .crc_q(crc_q)
  );

  hdlc_bit_serializer #(.WORD_W(FCS_W), .RUN(5)) u_ser (
    .clk(clk), .rst_n(rst_n), .stb(bit_stb), .load_word(load_word), .load_len(load_len),
    .load_stuff(load_stuff), .need_load(need_load), .stuff_now(stuff_now),
    .emit_bit(emit_bit), .bit_q(tx_bit)
  );

  AST_READY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> bit_stb) else $error("ready outside strobe"); // R12
  AST_UNDERRUN_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> abort_done) else $error("underrun without abort"); // R10
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && abort_done)) else $error("frame and abort together"); // R9
  AST_ONES_UNITS: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_q == U_MARK || unit_q == U_ABORT) |-> tx_bit) else $error("zero in ones unit"); // R2
endmodule

// File: tb/tb_hdlc_tagged_tx.sv
module tb_hdlc_tagged_tx;
  localparam int RAWN = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, fill_flags = 1'b0;
  logic bit_stb, in_valid, in_ready, in_eop, in_abort;
  logic [7:0] in_data;
  logic tx_bit, frame_done, abort_done, underrun;

  always #10 clk = ~clk;

  logic [7:0] q_d [64];
  logic       q_e [64];
  logic       q_a [64];
  logic [5:0] head = '0, tail = '0;
  assign in_valid = (head != tail);
  assign in_data  = q_d[head];
  assign in_eop   = q_e[head];
  assign in_abort = q_a[head];

  logic [1:0] stb_cnt = '0;
  logic stb_seen = 1'b0;
  assign bit_stb = rst_n && (stb_cnt == 2'd3);

  hdlc_tagged_tx dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .fill_flags(fill_flags), .bit_stb(bit_stb),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_eop(in_eop),
    .in_abort(in_abort), .tx_bit(tx_bit), .frame_done(frame_done),
    .abort_done(abort_done), .underrun(underrun)
  );

  int checks = 0, errors = 0;
  int nbits = 0, first_zero = -1, fd_idx = 0, ab_idx = 0, n_fd = 0, n_ab = 0, n_un = 0;
  int bad_ready = 0, npops = 0, bad_hold = 0;
  int pop_idx [64];
  logic raw [RAWN];
  logic prev_bit = 1'b1;

  // bench-side receiver
  int ones = 0, cnt = 0, gap = 0, rx_n = 0, rx_wr = 0, rx_aborts = 0, rx_abort_bits = 0;
  int rx_stuffed = 0, rx_bad = 0;
  logic bitbuf [1024];
  logic [7:0] rx_mem [128];
  int rx_len [16], rx_base [16], rx_gap [16];
  logic rx_ok [16];
  logic [7:0] exp_b [8];

  task automatic push_bit(input logic b);
    if (cnt < 1024) bitbuf[cnt] = b;
    cnt++;
  endtask

  task automatic rx_frame(input int nb);
    logic [15:0] c;
    logic [7:0] by;
    c = 16'hFFFF;
    for (int i = 0; i < nb; i++) begin
      for (int k = 0; k < 8; k++) by[k] = bitbuf[i*8+k];
      if (i < nb - 2 && rx_wr < 128) begin rx_mem[rx_wr] = by; rx_wr++; end
      for (int k = 0; k < 8; k++) c = (c >> 1) ^ ((c[0] ^ by[k]) ? 16'h8408 : 16'h0000);
    end
    if (rx_n < 16) begin
      rx_ok[rx_n] = (c == 16'hF0B8);
      rx_len[rx_n] = nb - 2;
      rx_base[rx_n] = rx_wr - (nb - 2);
      rx_gap[rx_n] = gap;
    end
    rx_n++;
    gap = 0;
  endtask

  task automatic rx_bit(input logic b);
    int eff;
    if (b) begin
      ones++;
      if (ones < 7) push_bit(1'b1);
      else if (ones == 7) begin
        if (cnt > 6) begin rx_aborts++; rx_abort_bits = cnt - 6; end
        cnt = 0;
      end
    end else begin
      if (ones == 5) rx_stuffed++;
      else if (ones == 6) begin
        eff = (cnt >= 7) ? cnt - 7 : 0;
        if (eff == 0) gap++;
        else if (eff % 8 == 0 && eff >= 24) rx_frame(eff / 8);
        else rx_bad++;
        cnt = 0;
      end else push_bit(1'b0);
      ones = 0;
    end
  endtask

  always @(posedge clk) begin
    stb_cnt  <= rst_n ? stb_cnt + 2'd1 : 2'd0;
    stb_seen <= bit_stb;
    if (in_valid && in_ready) begin
      head <= head + 6'd1;
      if (!bit_stb) bad_ready <= bad_ready + 1;
      if (npops < 64) pop_idx[npops] <= nbits;
      npops <= npops + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!stb_seen && tx_bit !== prev_bit) bad_hold++;
      prev_bit = tx_bit;
      if (stb_seen) begin
        if (nbits < RAWN) raw[nbits] = tx_bit;
        if (!tx_bit && first_zero < 0) first_zero = nbits;
        rx_bit(tx_bit);
        nbits++;
      end
      if (frame_done) begin fd_idx = nbits - 1; n_fd++; end
      if (abort_done) begin ab_idx = nbits - 1; n_ab++; end
      if (underrun) n_un++;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic e, input logic a);
    q_d[tail] = d; q_e[tail] = e; q_a[tail] = a;
    tail = tail + 6'd1;
  endtask

  task automatic wait_bits(input int n);
    repeat (n * 4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_count(ref int ctr, input int target);
    for (int i = 0; i < 4000 && ctr < target; i++) @(negedge clk);
  endtask

  function automatic logic flag_bit(input int k);
    return (k % 8 == 0 || k % 8 == 7) ? 1'b0 : 1'b1;
  endfunction

  function automatic int is_flag_at(input int s);
    for (int k = 0; k < 8; k++) if (s + k < 0 || s + k >= RAWN || raw[s+k] !== flag_bit(k)) return 0;
    return 1;
  endfunction

  function automatic int ones_at(input int s, input int n);
    for (int k = 0; k < n; k++) if (s + k >= RAWN || raw[s+k] !== 1'b1) return 0;
    return 1;
  endfunction

  task automatic check_frame(input int idx, input int len, input string tag);
    int ok;
    ok = (idx < rx_n) && rx_ok[idx] && rx_len[idx] == len;
    if (ok) for (int i = 0; i < len; i++) if (rx_mem[rx_base[idx]+i] != exp_b[i]) ok = 0;
    check(ok != 0, tag, (idx < rx_n) ? rx_len[idx] : -1, len);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(tx_bit === 1'b1 && in_ready === 1'b0, "R1 reset line/ready", tx_bit, 1);
    check(!frame_done && !abort_done && !underrun, "R1 reset pulses", frame_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_bit === 1'b1 && !frame_done && !abort_done && !underrun, "R1 after release", tx_bit, 1);
  endtask

  task automatic t_mark_idle;
    tx_en = 1'b1; fill_flags = 1'b0;
    wait_bits(40);
    check(first_zero < 0, "R2 ones idle", first_zero, -1);
  endtask

  task automatic t_mark_start;
    int p0, fd0;
    exp_b[0] = 8'hFF; exp_b[1] = 8'h7E; exp_b[2] = 8'hF8; exp_b[3] = 8'h3C;
    p0 = npops; fd0 = n_fd;
    push(8'hFF, 0, 0); push(8'h7E, 0, 0); push(8'hF8, 0, 0); push(8'h3C, 1, 0);
    wait_count(n_fd, fd0 + 1);
    wait_bits(30);
    check(first_zero % 8 == 0, "R4 ones group completed", first_zero % 8, 0);
    check(is_flag_at(pop_idx[p0] - 8) == 1, "R4 opening flag before data", pop_idx[p0], 0);
    check_frame(0, 4, "R7 frame 1 bytes and checksum");
    check(rx_stuffed > 0, "R6 zero insertion seen", rx_stuffed, 1);
    check(is_flag_at(fd_idx) == 1, "R6 closing flag unstuffed", fd_idx, 0);
    check(ones_at(fd_idx + 8, 16) == 1, "R11 back to ones idle", 0, 1);
  endtask

  task automatic t_flag_idle;
    int s, hit;
    fill_flags = 1'b1;
    wait_bits(32);
    s = nbits - 24; hit = 0;
    for (int o = 0; o < 8; o++) if (is_flag_at(s + o) && is_flag_at(s + o + 8)) hit = 1;
    check(hit == 1, "R3 flag idle pattern", hit, 1);
  endtask

  task automatic t_flag_start;
    int pi, p0, fd0;
    exp_b[0] = 8'h55; exp_b[1] = 8'hA0;
    pi = nbits; p0 = npops; fd0 = n_fd;
    push(8'h55, 0, 0); push(8'hA0, 1, 0);
    wait_count(n_fd, fd0 + 1);
    wait_bits(30);
    check(pop_idx[p0] - pi <= 8, "R5 current flag opens frame", pop_idx[p0] - pi, 8);
    check(is_flag_at(pop_idx[p0] - 8) == 1, "R5 flag precedes data", 0, 1);
    check_frame(1, 2, "R7 frame 2 in flag mode");
    check(is_flag_at(fd_idx + 8) == 1, "R11 back to flag idle", 0, 1);
  endtask

  task automatic t_back2back;
    int fd0;
    fill_flags = 1'b0;
    wait_bits(16);
    fd0 = n_fd;
    push(8'h81, 0, 0); push(8'h3F, 1, 0);
    push(8'hC3, 0, 0); push(8'h0F, 0, 0); push(8'hFE, 1, 1'b0);
    wait_count(n_fd, fd0 + 2);
    wait_bits(30);
    exp_b[0] = 8'h81; exp_b[1] = 8'h3F;
    check_frame(2, 2, "R8 first queued packet");
    exp_b[0] = 8'hC3; exp_b[1] = 8'h0F; exp_b[2] = 8'hFE;
    check_frame(3, 3, "R8 second queued packet");
    check(rx_n > 3 && rx_gap[3] == 0, "R8 single flag between packets", rx_n > 3 ? rx_gap[3] : -1, 0);
  endtask

  task automatic t_abort_tag;
    int ab0, n0, a0, u0;
    ab0 = n_ab; n0 = rx_n; a0 = rx_aborts; u0 = n_un;
    push(8'h11, 0, 0); push(8'h22, 0, 0); push(8'h33, 1, 1);
    wait_count(n_ab, ab0 + 1);
    wait_bits(30);
    check(rx_aborts == a0 + 1 && rx_abort_bits == 16, "R9 earlier bytes sent then abort", rx_abort_bits, 16);
    check(ones_at(ab_idx, 8) == 1, "R9 abort is eight ones", 0, 1);
    check(head == tail && rx_n == n0, "R9 tagged byte consumed, no frame", rx_n, n0);
    check(n_un == u0, "R9 no underrun on tag", n_un, u0);
    check(ones_at(ab_idx + 8, 16) == 1, "R11 ones idle after abort", 0, 1);
  endtask

  task automatic t_underrun;
    int ab0, u0;
    ab0 = n_ab; u0 = n_un;
    push(8'h44, 0, 0);
    wait_count(n_ab, ab0 + 1);
    wait_bits(20);
    check(n_un == u0 + 1, "R10 underrun pulse", n_un, u0 + 1);
    check(rx_abort_bits == 8 && ones_at(ab_idx, 8) == 1, "R10 abort after lone byte", rx_abort_bits, 8);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin q_d[i] = '0; q_e[i] = 1'b0; q_a[i] = 1'b0; end
    t_reset();
    t_mark_idle();
    t_mark_start();
    t_flag_idle();
    t_flag_start();
    t_back2back();
    t_abort_tag();
    t_underrun();
    check(bad_ready == 0, "R12 ready only with strobe", bad_ready, 0);
    check(bad_hold == 0, "R12 line holds between strobes", bad_hold, 0);
    check(rx_bad == 0, "R6 no malformed frames", rx_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule